// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Bit Noise Vote

This block takes an asynchronous serial line, synchronizes it, and recovers character frames from it. The line is divided into bit periods of sixteen oversampling ticks. Each tick comes from a clock enable whose period is set by a divisor input. When the line goes low while idle, the block treats that as a possible start of frame. It then confirms the start bit at its centre, collects the data bits least significant first, optionally collects a parity bit, and checks the stop bit.

Every bit in the frame is sampled three times around its centre, one tick apart. This applies to the start bit and the stop bit as well as the data and parity bits. The bit value is the majority of the three samples. Any disagreement among the three marks the frame as noisy, but the data is still taken from the majority.

Finished characters go to a host register with a level valid flag. Three sticky error flags sit alongside it: framing, parity and noise. All of these hold until the host acknowledges. The intended line rate is 57600 bit/s, which sets the divisor as (clock frequency) / (16 × 57600).

Top module: `uart_noise_rx`

## Requirements
- R1: After reset, `rx_valid`, `err_frame`, `err_parity` and `err_noise` are 0.
- R2: An oversampling tick occurs once every `divisor` clock cycles. A divisor of 0 acts as 1. One bit period lasts 16 ticks.
- R3: A frame is a low start bit, then DATA_W data bits least significant first, then an optional parity bit, then a high stop bit. The data appears on `rx_data`, and `rx_valid` goes high in the cycle after the stop bit is evaluated.
- R4: Each bit is sampled at oversampling positions 7, 8 and 9 of its period, counted from the tick on which the falling edge was seen. The bit value is the majority of these three samples, so a single deviant sample does not alter the data.
- R5: `err_noise` is set for a frame when the three samples of any of its bits differ. This includes the start bit and the stop bit.
- R6: If the majority of the start-bit samples is high, the receiver returns to idle and produces no character.
- R7: `err_frame` is set when the majority of the stop-bit samples is low.
- R8: Parity applies only when `par_en` = 1. With `par_odd` = 1, the data bits plus the parity bit must hold an odd number of ones. With `par_odd` = 0, they must hold an even number. A mismatch sets `err_parity`.
- R9: `rx_valid`, `rx_data` and the error flags hold until `ack` is seen. If a new character completes before the acknowledge, it replaces `rx_data`, and its error flags are ORed into the held ones.
- R10: An `ack` in a cycle with no completing character clears `rx_valid` and all error flags on the next edge.
- R11: `rxd` passes through a two-stage synchronizer that resets to the idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W | Clock cycles per oversampling tick (0 acts as 1) |
| par_en | input | 1 | Static: parity bit present |
| par_odd | input | 1 | Static: 1 = odd parity, 0 = even |
| rxd | input | 1 | Asynchronous serial line, idle high |
| ack | input | 1 | Host acknowledges the held character |
| rx_data | output | DATA_W | Received character |
| rx_valid | output | 1 | Character held and not yet acknowledged |
| err_frame | output | 1 | Sticky stop-bit error |
| err_parity | output | 1 | Sticky parity error |
| err_noise | output | 1 | Sticky three-sample disagreement |

## Verification
The bench keeps the defaults DATA_W = 8 and DIV_W = 16, and changes `divisor` at run time to 0, 1 and 3. With a divisor of 1, every oversampling tick is one clock, so a single-clock glitch placed at a bit centre lands on exactly one of the three votes. This makes noise on the start, data and stop bits repeatable. The divisor of 3 exercises the tick spacing, and the divisor of 0 exercises the treatment of zero as one. Parity is run with the parity bit off, in odd mode and in even mode. The bench also covers a short false start, a low stop bit, and two characters arriving before an acknowledge.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } urx_state_e;

  localparam int unsigned OS_RATE  = 16;
  localparam int unsigned OS_W     = $clog2(OS_RATE);
  localparam logic [OS_W-1:0] OS_S0   = OS_W'(7);
  localparam logic [OS_W-1:0] OS_S1   = OS_W'(8);
  localparam logic [OS_W-1:0] OS_S2   = OS_W'(9);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
endpackage

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= limit) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      tick  <= 1'b0;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor > DIV_W'(1)) |=> (!tick || divisor != $past(divisor)));
endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

  // R11
  sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout);
endmodule

// File: rtl/urx_vote.sv
module urx_vote (
  input  logic [2:0] smp,
  output logic       level,
  output logic       noisy
);
  always_comb begin
    level = (smp[0] & smp[1]) | (smp[1] & smp[2]) | (smp[0] & smp[2]);
    noisy = (smp != 3'b000) && (smp != 3'b111);
  end
endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
  import urx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              f_err,
  output logic              p_err,
  output logic              n_err
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  urx_state_e        state_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic              s0_q, s1_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;
  logic              noise_q;
  logic              maj, nz;

  urx_vote vote_i (
    .smp   ({line, s1_q, s0_q}),
    .level (maj),
    .noisy (nz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      s0_q    <= 1'b1;
      s1_q    <= 1'b1;
      shift_q <= '0;
      par_q   <= 1'b0;
      noise_q <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      f_err   <= 1'b0;
      p_err   <= 1'b0;
      n_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state_q == ST_IDLE) begin
          if (!line) begin
            state_q <= ST_START;
            os_q    <= '0;
            noise_q <= 1'b0;
          end
        end else begin
          os_q <= os_q + OS_W'(1);
          if (os_q == OS_S0) s0_q <= line;
          if (os_q == OS_S1) s1_q <= line;
          if (os_q == OS_S2) begin
            case (state_q)
              ST_START: begin
                if (maj) state_q <= ST_IDLE;
                else     noise_q <= noise_q | nz;
              end
              ST_DATA: begin
                shift_q <= {maj, shift_q[DATA_W-1:1]};
                noise_q <= noise_q | nz;
              end
              ST_PARITY: begin
                par_q   <= maj;
                noise_q <= noise_q | nz;
              end
              ST_STOP: begin
                done    <= 1'b1;
                data    <= shift_q;
                f_err   <= !maj;
                p_err   <= par_en && (^shift_q ^ par_q ^ par_odd);
                n_err   <= noise_q | nz;
                state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
          if (os_q == OS_LAST) begin
            case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ST_DATA: begin
                if (idx_q == IDX_LAST) state_q <= par_en ? ST_PARITY : ST_STOP;
                else                   idx_q   <= idx_q + IDX_W'(1);
              end
              ST_PARITY: state_q <= ST_STOP;
              default:   state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_q == ST_IDLE || state_q == ST_START));
endmodule

// File: rtl/uart_noise_rx.sv
module uart_noise_rx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  input  logic              ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_noise
);
  logic              tick;
  logic              line_s;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_fe, f_pe, f_ne;
  logic              keep;

  urx_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .tick    (tick)
  );

  urx_sync #(.STAGES(2)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  urx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .line    (line_s),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (f_done),
    .data    (f_data),
    .f_err   (f_fe),
    .p_err   (f_pe),
    .n_err   (f_ne)
  );

  assign keep = rx_valid && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      err_noise  <= 1'b0;
    end else if (f_done) begin
      rx_data    <= f_data;
      rx_valid   <= 1'b1;
      err_frame  <= f_fe | (keep & err_frame);
      err_parity <= f_pe | (keep & err_parity);
      err_noise  <= f_ne | (keep & err_noise);
    end else if (ack) begin
      rx_valid   <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      err_noise  <= 1'b0;
    end
  end

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !ack && !f_done) |=> (rx_valid && $stable(rx_data)));

  // R9
  sticky_noise_chk: assert property (@(posedge clk) disable iff (rst)
    (err_noise && !ack) |=> err_noise);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !f_done) |=> (!rx_valid && !err_frame && !err_parity && !err_noise));

  // R3
  done_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    f_done |=> rx_valid);
endmodule

// File: tb/uart_noise_rx_tb_top.sv
module uart_noise_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int VW = 16;

  typedef struct {
    logic [DW-1:0] d;
    logic fe, pe, ne;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [VW-1:0] divisor = VW'(1);
  logic          par_en = 1'b0, par_odd = 1'b0;
  logic          rxd = 1'b1;
  logic          ack = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_valid, err_frame, err_parity, err_noise;

  int   total = 0, bad = 0;
  bit   auto_ack = 1'b1;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_noise_rx #(.DATA_W(DW), .DIV_W(VW)) dut_i (
    .clk(clk), .rst(rst), .divisor(divisor), .par_en(par_en), .par_odd(par_odd),
    .rxd(rxd), .ack(ack), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_frame(err_frame), .err_parity(err_parity), .err_noise(err_noise)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clk_per_tick();
    return (divisor == '0) ? 1 : int'(divisor);
  endfunction

  // gbit: 0 = start, 1..DW = data, then parity (if enabled), then stop; -1 = none
  task automatic send_frame(input logic [DW-1:0] d, input bit flip_par,
                            input bit stop_v, input int gbit, input bit push);
    logic bits[$];
    int   cpt;
    exp_t e;
    logic p;
    bits.push_back(1'b0);
    for (int i = 0; i < DW; i++) bits.push_back(d[i]);
    p = ^d ^ par_odd ^ flip_par;
    if (par_en) bits.push_back(p);
    bits.push_back(stop_v);
    e.d  = d;
    e.fe = !stop_v;
    e.pe = par_en && flip_par;
    e.ne = (gbit >= 0);
    if (push) sb_q.push_back(e);
    cpt = clk_per_tick();
    for (int b = 0; b < bits.size(); b++) begin
      for (int c = 0; c < 16 * cpt; c++) begin
        @(negedge clk);
        rxd = (b == gbit && c == 9) ? ~bits[b] : bits[b];
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (24 * cpt) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rx_valid && auto_ack) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          check("R6 unexpected character", 32'(rx_data), 32'hFFFF_FFFF);
        end else begin
          e = sb_q.pop_front();
          check("R3 data", 32'(rx_data), 32'(e.d));
          check("R7 frame err", 32'(err_frame), 32'(e.fe));
          check("R8 parity err", 32'(err_parity), 32'(e.pe));
          check("R5 noise err", 32'(err_noise), 32'(e.ne));
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R10 valid cleared", 32'(rx_valid), 32'd0);
        check("R10 flags cleared", 32'({err_frame, err_parity, err_noise}), 32'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(rx_valid), 32'd0);
    check("R1 flags", 32'({err_frame, err_parity, err_noise}), 32'd0);
    // R11 idle line produces nothing
    repeat (40) @(negedge clk);
    check("R11 idle", 32'(rx_valid), 32'd0);

    // R3 plain frames, divisor 1, no parity
    send_frame(8'hA5, 0, 1, -1, 1);
    send_frame(8'h00, 0, 1, -1, 1);
    send_frame(8'hFF, 0, 1, -1, 1);
    // R2 divisor 3 and divisor 0
    divisor = VW'(3);
    send_frame(8'h3C, 0, 1, -1, 1);
    divisor = VW'(0);
    send_frame(8'h81, 0, 1, -1, 1);
    divisor = VW'(1);

    // R4 R5 noise on start, data and stop keeps majority data
    send_frame(8'h5A, 0, 1, 0, 1);
    send_frame(8'h5A, 0, 1, 3, 1);
    send_frame(8'hC3, 0, 1, 9, 1);

    // R7 low stop bit
    send_frame(8'h7E, 0, 0, -1, 1);

    // R8 parity, odd then even, good and bad
    par_en  = 1'b1;
    par_odd = 1'b1;
    send_frame(8'h13, 0, 1, -1, 1);
    send_frame(8'h13, 1, 1, -1, 1);
    par_odd = 1'b0;
    send_frame(8'h13, 0, 1, -1, 1);
    send_frame(8'hE4, 1, 1, -1, 1);
    send_frame(8'hE4, 0, 1, 9, 1);
    par_en = 1'b0;

    // R6 false start: short low pulse
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    check("R6 false start ignored", 32'(rx_valid), 32'd0);

    // R9 two characters before acknowledge: newest data, merged flags
    auto_ack = 1'b0;
    send_frame(8'h11, 0, 1, 2, 0);
    check("R9 held valid", 32'(rx_valid), 32'd1);
    check("R9 held data", 32'(rx_data), 32'h11);
    send_frame(8'h22, 0, 1, -1, 0);
    begin
      exp_t e;
      e.d = 8'h22; e.fe = 1'b0; e.pe = 1'b0; e.ne = 1'b1;
      sb_q.push_back(e);
    end
    auto_ack = 1'b1;
    repeat (20) @(negedge clk);

    check("R3 all expected characters seen", 32'(sb_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule